// File: doc/BRIEF.md
# Condition-Truncated Vector Loop Sequencer

This block walks a vector operation one element at a time, from element 0 upward, and shortens the vector length as soon as a per-element condition test fails. A start pulse latches the requested length and the test setup. The block then asks an external ALU stream for one signed result per step. Each result is turned into a 4-bit condition field. One bit of that field is tested, and the block drives write enables for the result and for the condition field, together with the element index.

When the loop ends it returns the new vector length with a one-cycle done pulse. The loop ends on a failing test, or after the last element when nothing fails. The length can only shrink because a test failed. A failure on the very first element can legally give a length of zero. A compare-only setting turns the operation into a pure compare: condition fields are written but results never are.

Top module: `ffirst_ctrl`

## Requirements
- R1: After an accepted start with a nonzero length, elements are consumed strictly in order 0, 1, 2, … with one element per cycle in which `elem_valid` is high while `elem_req` is high. Each consumed element shows up one cycle later with `out_valid` high and `out_idx` equal to its index.
- R2: The condition field `out_cr` is {lt, gt, eq, so} at bits 3, 2, 1 and 0. It comes from a signed compare of the element result against zero. `so` is always 0, and exactly one of lt, gt and eq is 1.
- R3: With `cfg_rc`=1, `cfg_sel` picks the tested bit: 0 picks lt, 1 picks gt, 2 picks eq and 3 picks so. With `cfg_rc`=0, the eq bit is tested whatever `cfg_sel` holds.
- R4: An element fails when its tested bit equals `cfg_inv`.
- R5: Without inclusion, the failing element and every later element are discarded. No write enable is raised for the failing element, no further element is requested, and `new_vl` equals the failing index.
- R6: With `cfg_incl`=1 and `cfg_rc`=0, `new_vl` is the failing index plus one. The failing element is committed under the write rules of R12.
- R7: `cfg_incl` has no effect when `cfg_rc`=1. Truncation is then exclusive.
- R8: A failure at element 0 without inclusion yields `new_vl`=0. A start with `vl_in`=0 yields done one cycle later with `new_vl`=0 and consumes no element.
- R9: With `cfg_cmp_only`=1, `res_we` is never raised. `cr_we` is raised for every committed element.
- R10: If no element fails, `new_vl` equals the started length. The length is never reduced except by a failing test.
- R11: `done` is a single-cycle pulse, valid together with `new_vl`, in the same cycle as the last element's `out_valid`. After it, `elem_req` is low until the next start.
- R12: A committed element raises `res_we` when `cfg_cmp_only`=0. It raises `cr_we` when `cfg_rc`=1 or `cfg_cmp_only`=1. `out_data` carries the element result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted while idle |
| vl_in | input | VLW | Requested vector length |
| cfg_sel | input | 2 | Condition bit select used when Rc=1 |
| cfg_inv | input | 1 | Value of the tested bit that counts as failure |
| cfg_incl | input | 1 | Keep the failing element in the count (Rc=0 only) |
| cfg_cmp_only | input | 1 | Write condition fields only, never results |
| cfg_rc | input | 1 | Rc flag: selectable bit test versus zero test |
| elem_valid | input | 1 | ALU stream offers a result this cycle |
| elem_data | input | DW | Signed element result |
| elem_req | output | 1 | Sequencer is waiting for the next element |
| out_valid | output | 1 | An element step completed |
| out_idx | output | VLW | Index of the completed element |
| out_data | output | DW | Result of the completed element |
| out_cr | output | 4 | Condition field {lt, gt, eq, so} |
| cr_we | output | 1 | Commit the condition field |
| res_we | output | 1 | Commit the result |
| done | output | 1 | Loop finished, `new_vl` valid |
| new_vl | output | VLW | Resulting vector length |

## Verification
The bench aims at a failure on element 0 and at a start with zero length. A design that clamps the length to at least one, or that waits for an element, would return 1 or hang. Inclusive and exclusive truncation run on the same data. An off-by-one would show as a wrong length or as a write enable on the discarded element. The inclusive flag is also set together with Rc=1, where a design that honours it would return one element too many. A compare-only run catches any result write that leaks through. Stalled streams and the so-bit select catch a design that advances without data or tests the wrong bit.

// File: rtl/ffl_pkg.sv
package ffl_pkg;

    localparam int CR_LT = 3;
    localparam int CR_GT = 2;
    localparam int CR_EQ = 1;
    localparam int CR_SO = 0;

    typedef struct packed {
        logic [1:0] sel;
        logic       inv;
        logic       incl;
        logic       cmp_only;
        logic       rc;
    } ffl_cfg_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ffl_state_t;

    function automatic logic pick_test_bit(input logic [3:0] cr,
                                           input logic [1:0] sel,
                                           input logic       rc);
        logic b;
        if (!rc) begin
            b = cr[CR_EQ];
        end else begin
            case (sel)
                2'd0:    b = cr[CR_LT];
                2'd1:    b = cr[CR_GT];
                2'd2:    b = cr[CR_EQ];
                default: b = cr[CR_SO];
            endcase
        end
        return b;
    endfunction

    function automatic logic incl_effective(input ffl_cfg_t c);
        return c.incl & ~c.rc;
    endfunction

endpackage

// File: rtl/ffl_cond_eval.sv
module ffl_cond_eval
    import ffl_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] data,
    input  ffl_cfg_t      cfg,
    output logic [3:0]    cr,
    output logic          fail,
    output logic          keep
);
    logic signed [DW-1:0] sdata;
    logic                 tbit;

    always_comb begin
        sdata      = signed'(data);
        cr         = '0;
        cr[CR_LT]  = (sdata < 0);
        cr[CR_GT]  = (sdata > 0);
        cr[CR_EQ]  = (sdata == 0);
        cr[CR_SO]  = 1'b0;
        tbit       = pick_test_bit(cr, cfg.sel, cfg.rc);
        fail       = (tbit == cfg.inv);
        keep       = ~fail | incl_effective(cfg);
    end
endmodule

// File: rtl/ffl_step_ctr.sv
module ffl_step_ctr
    import ffl_pkg::*;
#(
    parameter int VLW = 7
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [VLW-1:0] vl_in,
    input  logic           step,
    input  logic           fail,
    input  logic           incl_eff,
    output logic           busy,
    output logic           accept,
    output logic [VLW-1:0] idx,
    output logic           done,
    output logic [VLW-1:0] new_vl
);
    ffl_state_t     state;
    logic [VLW-1:0] vl_q;
    logic           last;

    assign busy   = (state == ST_RUN);
    assign accept = start & ~busy;
    assign last   = (idx == vl_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            vl_q   <= '0;
            idx    <= '0;
            done   <= 1'b0;
            new_vl <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        vl_q <= vl_in;
                        idx  <= '0;
                        if (vl_in == '0) begin
                            done   <= 1'b1;
                            new_vl <= '0;
                        end else begin
                            state <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (step) begin
                        if (fail) begin
                            done   <= 1'b1;
                            new_vl <= idx + VLW'(incl_eff);
                            state  <= ST_IDLE;
                        end else if (last) begin
                            done   <= 1'b1;
                            new_vl <= vl_q;
                            state  <= ST_IDLE;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ffirst_ctrl.sv
module ffirst_ctrl
    import ffl_pkg::*;
#(
    parameter int VL_MAX = 64,
    parameter int DW     = 16,
    localparam int VLW   = $clog2(VL_MAX + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [VLW-1:0] vl_in,
    input  logic [1:0]     cfg_sel,
    input  logic           cfg_inv,
    input  logic           cfg_incl,
    input  logic           cfg_cmp_only,
    input  logic           cfg_rc,
    input  logic           elem_valid,
    input  logic [DW-1:0]  elem_data,
    output logic           elem_req,
    output logic           out_valid,
    output logic [VLW-1:0] out_idx,
    output logic [DW-1:0]  out_data,
    output logic [3:0]     out_cr,
    output logic           cr_we,
    output logic           res_we,
    output logic           done,
    output logic [VLW-1:0] new_vl
);
    ffl_cfg_t       cfg_q;
    ffl_cfg_t       cfg_in;
    logic           busy;
    logic           accept;
    logic           step;
    logic [VLW-1:0] idx;
    logic [3:0]     cr;
    logic           fail;
    logic           keep;

    assign cfg_in = '{sel: cfg_sel, inv: cfg_inv, incl: cfg_incl,
                      cmp_only: cfg_cmp_only, rc: cfg_rc};

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (accept) cfg_q <= cfg_in;
    end

    assign step     = busy & elem_valid;
    assign elem_req = busy;

    ffl_cond_eval #(.DW(DW)) u_eval (
        .data (elem_data),
        .cfg  (cfg_q),
        .cr   (cr),
        .fail (fail),
        .keep (keep)
    );

    ffl_step_ctr #(.VLW(VLW)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .vl_in    (vl_in),
        .step     (step),
        .fail     (fail),
        .incl_eff (incl_effective(cfg_q)),
        .busy     (busy),
        .accept   (accept),
        .idx      (idx),
        .done     (done),
        .new_vl   (new_vl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_idx   <= '0;
            out_data  <= '0;
            out_cr    <= '0;
            cr_we     <= 1'b0;
            res_we    <= 1'b0;
        end else begin
            out_valid <= step;
            cr_we     <= step & keep & (cfg_q.rc | cfg_q.cmp_only);
            res_we    <= step & keep & ~cfg_q.cmp_only;
            if (step) begin
                out_idx  <= idx;
                out_data <= elem_data;
                out_cr   <= cr;
            end
        end
    end
endmodule

// File: rtl/ffirst_ctrl_chk.sv
module ffirst_ctrl_chk #(
    parameter int VLW = 7,
    parameter int DW  = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [VLW-1:0] vl_in,
    input logic           cfg_cmp_only,
    input logic           elem_req,
    input logic           out_valid,
    input logic [VLW-1:0] out_idx,
    input logic [3:0]     out_cr,
    input logic           cr_we,
    input logic           res_we,
    input logic           done,
    input logic [VLW-1:0] new_vl
);
    logic           acc;
    logic [VLW-1:0] vl_sh;
    logic           cmp_sh;
    logic [VLW-1:0] exp_idx;

    assign acc = start & ~elem_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            vl_sh   <= '0;
            cmp_sh  <= 1'b0;
            exp_idx <= '0;
        end else if (acc) begin
            vl_sh   <= vl_in;
            cmp_sh  <= cfg_cmp_only;
            exp_idx <= '0;
        end else if (out_valid) begin
            exp_idx <= out_idx + 1'b1;
        end
    end

    assert_index_order_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_idx == exp_idx);

    assert_cr_shape_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_cr[0] == 1'b0 && $countones(out_cr[3:1]) == 1));

    assert_no_request_after_end_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> !elem_req);

    assert_no_result_write_R9: assert property (@(posedge clk) disable iff (rst)
        res_we |-> !cmp_sh);

    assert_length_never_grows_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> new_vl <= vl_sh);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        (done && !(start && vl_in == '0)) |=> !done);

    assert_we_with_step_R12: assert property (@(posedge clk) disable iff (rst)
        (res_we || cr_we) |-> out_valid);
endmodule

bind ffirst_ctrl ffirst_ctrl_chk #(.VLW(VLW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .vl_in        (vl_in),
    .cfg_cmp_only (cfg_cmp_only),
    .elem_req     (elem_req),
    .out_valid    (out_valid),
    .out_idx      (out_idx),
    .out_cr       (out_cr),
    .cr_we        (cr_we),
    .res_we       (res_we),
    .done         (done),
    .new_vl       (new_vl)
);

// File: tb/tb_ffirst_ctrl.sv
`timescale 1ns/1ps
module tb_ffirst_ctrl;
    localparam int VL_MAX = 64;
    localparam int DW     = 16;
    localparam int VLW    = $clog2(VL_MAX + 1);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [VLW-1:0] vl_in = '0;
    logic [1:0]     cfg_sel = '0;
    logic           cfg_inv = 1'b0, cfg_incl = 1'b0, cfg_cmp_only = 1'b0, cfg_rc = 1'b0;
    logic           elem_valid = 1'b0;
    logic [DW-1:0]  elem_data = '0;
    logic           elem_req, out_valid, cr_we, res_we, done;
    logic [VLW-1:0] out_idx, new_vl;
    logic [DW-1:0]  out_data;
    logic [3:0]     out_cr;

    int n_chk = 0;
    int n_fail = 0;
    logic signed [DW-1:0] dat [0:15];

    always #4 clk = ~clk;

    ffirst_ctrl #(.VL_MAX(VL_MAX), .DW(DW)) dut (
        .clk(clk), .rst(rst), .start(start), .vl_in(vl_in),
        .cfg_sel(cfg_sel), .cfg_inv(cfg_inv), .cfg_incl(cfg_incl),
        .cfg_cmp_only(cfg_cmp_only), .cfg_rc(cfg_rc),
        .elem_valid(elem_valid), .elem_data(elem_data), .elem_req(elem_req),
        .out_valid(out_valid), .out_idx(out_idx), .out_data(out_data),
        .out_cr(out_cr), .cr_we(cr_we), .res_we(res_we),
        .done(done), .new_vl(new_vl)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Independent model of the condition field: {lt,gt,eq,so}
    function automatic logic [3:0] model_cr(input logic signed [DW-1:0] d);
        return {d < 0, d > 0, d == 0, 1'b0};
    endfunction

    task automatic run_case(input string name, input int vl, input logic [1:0] sel,
                            input logic inv, input logic incl, input logic cmp,
                            input logic rc, input bit stall);
        logic [3:0] ecr;
        logic tb_bit, f, kp, inc_eff;
        int exp_vl;
        @(negedge clk);
        vl_in = VLW'(vl); cfg_sel = sel; cfg_inv = inv; cfg_incl = incl;
        cfg_cmp_only = cmp; cfg_rc = rc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (vl == 0) begin
            chk(done == 1'b1, {name, " R8 zero-length done"}, done, 1);
            chk(new_vl == 0, {name, " R8 zero-length new_vl"}, new_vl, 0);
            chk(elem_req == 1'b0, {name, " R8 no element requested"}, elem_req, 0);
            @(negedge clk);
            chk(done == 1'b0, {name, " R11 pulse ends"}, done, 0);
            return;
        end
        inc_eff = incl & ~rc;
        exp_vl = vl;
        for (int i = 0; i < vl; i++) begin
            ecr = model_cr(dat[i]);
            tb_bit = rc ? ecr[3 - sel] : ecr[1];
            f = (tb_bit == inv);
            kp = !f || inc_eff;
            chk(elem_req == 1'b1, {name, " R1 element requested"}, elem_req, 1);
            if (stall && (i % 2 == 1)) begin
                elem_valid = 1'b0;
                @(negedge clk);
                chk(out_valid == 1'b0, {name, " R1 no step without valid"}, out_valid, 0);
            end
            elem_valid = 1'b1; elem_data = dat[i];
            @(negedge clk);
            elem_valid = 1'b0;
            chk(out_valid == 1'b1, {name, " R1 out_valid"}, out_valid, 1);
            chk(out_idx == VLW'(i), {name, " R1 index"}, out_idx, i);
            chk(out_cr == ecr, {name, " R2 condition field"}, out_cr, ecr);
            chk(out_data == dat[i], {name, " R12 data"}, out_data, dat[i]);
            chk(res_we == (kp && !cmp), {name, " R12/R9 res_we"}, res_we, kp && !cmp);
            chk(cr_we == (kp && (rc || cmp)), {name, " R12/R9 cr_we"}, cr_we, kp && (rc || cmp));
            if (f) exp_vl = i + (inc_eff ? 1 : 0);
            if (f || i == vl - 1) begin
                chk(done == 1'b1, {name, " R11 done with last step"}, done, 1);
                chk(new_vl == VLW'(exp_vl), {name, " R5/R6/R10 new_vl"}, new_vl, exp_vl);
                break;
            end else begin
                chk(done == 1'b0, {name, " R11 no early done"}, done, 0);
            end
        end
        chk(elem_req == 1'b0, {name, " R5 stops requesting"}, elem_req, 0);
        elem_valid = 1'b1; elem_data = '0;
        @(negedge clk);
        elem_valid = 1'b0;
        chk(out_valid == 1'b0, {name, " R5 no step after end"}, out_valid, 0);
        chk(done == 1'b0, {name, " R11 single-cycle done"}, done, 0);
    endtask

    task automatic fill(input int zero_at, input int sign);
        for (int k = 0; k < 16; k++) dat[k] = DW'(sign * (k + 3));
        if (zero_at >= 0) dat[zero_at] = '0;
    endtask

    task automatic t_reset;
        chk(done == 1'b0 && out_valid == 1'b0, "reset R11 outputs idle", {done, out_valid}, 0);
        chk(elem_req == 1'b0, "reset R1 no request", elem_req, 0);
        chk(new_vl == 0 && res_we == 0 && cr_we == 0, "reset R12 enables low", new_vl, 0);
    endtask

    // R10: nothing fails, length kept
    task automatic t_no_fail;   fill(-1, 1); run_case("nofail", 8, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); endtask
    // R4/R5: zero at 3, exclusive
    task automatic t_excl;      fill(3, 1);  run_case("excl", 8, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); endtask
    // R6: inclusive with Rc=0
    task automatic t_incl;      fill(3, -1); run_case("incl", 8, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1); endtask
    // R8: first element fails
    task automatic t_first;     fill(0, 1);  run_case("first", 5, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); endtask
    // R3/R7: Rc=1 lt test, incl ignored
    task automatic t_rc_lt;
        fill(-1, -1); dat[5] = 16'sd7;
        run_case("rc_lt", 10, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    endtask
    // R3: Rc=1 gt test with inv=1
    task automatic t_rc_gt;
        fill(-1, -1); dat[2] = 16'sd0; dat[4] = 16'sd9;
        run_case("rc_gt", 6, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask
    // R3: so select always 0, inv=0 fails at 0
    task automatic t_rc_so;     fill(-1, 1); run_case("rc_so", 4, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0); endtask
    // R9: compare-only
    task automatic t_cmp;       fill(2, 1);  run_case("cmp", 6, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); endtask
    // R8: zero length
    task automatic t_zero_len;  fill(-1, 1); run_case("zerolen", 0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); endtask
    // R1/R10: full length, stalls
    task automatic t_full;      fill(-1, 1); run_case("full", 16, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1); endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_no_fail();
        t_excl();
        t_incl();
        t_first();
        t_rc_lt();
        t_rc_gt();
        t_rc_so();
        t_cmp();
        t_zero_len();
        t_full();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule